// File: doc/BRIEF.md
# OFDM Guard Postfix and Edge Window Unit

This unit sits after an inverse FFT that has already rotated each symbol by a quarter period. Each OFDM symbol arrives as 64 complex time-domain samples. The unit passes those samples straight through. It also keeps the first 16 in a small buffer and replays them after the 64th. Each symbol therefore leaves as 80 samples, which are equivalent to a symbol with a 16-sample cyclic prefix. Because only 16 samples are held, output starts in the same cycle as input, without waiting for a whole symbol.

A light edge window softens the boundaries between symbols. The first output sample of each symbol is averaged with the previous symbol's sample at index 16. After the symbol that carries the end-of-frame flag, the unit emits one extra sample: the halved value of that sample at index 16. This closes the frame.

The output uses a valid/ready handshake that pushes back on the input. While the replay or the tail sample goes out, the upstream source is held off. A sticky flag reports any start-of-symbol mark that does not line up with the unit's own symbol position.

Top module: `ofdm_guard_window`

## Requirements
- R1: Every symbol produces exactly 80 output samples. The first 64 are the input samples in arrival order. The last 16 are input indices 0 to 15 of the same symbol, replayed in order without the edge blend.
- R2: While the 16 replay samples and the tail sample are output, in_ready stays low and no input is accepted.
- R3: The first output sample of a symbol is floor((x0 + e) / 2), computed separately for the real and imaginary lanes. Here x0 is the symbol's index 0 input and e is the index 16 sample of the previous symbol in the same frame.
- R4: in_last is sampled with the index 0 beat of a symbol. When it is 1, one extra sample floor(e / 2) follows that symbol's replay, where e is that symbol's index 16 sample. The next symbol then blends with zero.
- R5: The first symbol after reset blends with a zero term, so its first output is floor(x0 / 2).
- R6: During the first 64 output positions, an input sample leaves in the same cycle it is accepted. in_valid and in_ready high together always means out_valid and out_ready are high in that cycle.
- R7: When out_ready is low at any position, including during the replay, no sample is dropped or duplicated, and a pending replay or tail sample holds stable.
- R8: err_align is low after reset. It goes high, and stays high until reset, after any accepted input beat whose in_sos value (1 = start of symbol) differs from whether the beat is index 0 of a symbol. The symbol position counter does not respond to in_sos.
- R9: Averages use two's complement arithmetic with one extra guard bit and round toward negative infinity. Full-scale values of either sign do not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_re | input | SAMPLE_W | Input sample, real part |
| in_im | input | SAMPLE_W | Input sample, imaginary part |
| in_valid | input | 1 | Input sample present |
| in_sos | input | 1 | Marks index 0 of a symbol |
| in_last | input | 1 | With the index 0 beat: this symbol ends the frame |
| in_ready | output | 1 | Unit takes the input sample this cycle |
| out_re | output | SAMPLE_W | Output sample, real part |
| out_im | output | SAMPLE_W | Output sample, imaginary part |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the output sample |
| err_align | output | 1 | Sticky start-of-symbol misalignment flag |

## Verification
The hardest case to reach is a stall that lands inside the replay or on the tail sample, at the same moment the source has a new symbol waiting. The stimulus creates it by toggling out_ready pseudo-randomly and inserting input gaps across a whole frame. In that frame the output must stay stable while held, and every sample must be matched once, in order, against a scoreboard.

Full-scale symbols of both signs follow one another, which drives the rounding corners: a blend of -1, and an odd negative tail that rounds down. A final symbol with a stray start mark sets the alignment flag.

// File: rtl/gw_pkg.sv
`timescale 1ns/1ps
package gw_pkg;

   // Where the symbol sequencer currently stands
   typedef enum logic [1:0] {
      PH_PASS   = 2'd0,   // input flows straight to output
      PH_REPLAY = 2'd1,   // stored head samples are sent again
      PH_TAIL   = 2'd2    // single closing sample after a frame
   } gw_phase_e;

   localparam int GW_LANES = 2;   // real and imaginary

endpackage

// File: rtl/gw_hold_buf.sv
`timescale 1ns/1ps
module gw_hold_buf #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 32,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("gw_hold_buf: DEPTH must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/gw_blend.sv
`timescale 1ns/1ps
module gw_blend import gw_pkg::*; #(
   parameter int SAMPLE_W = 16
) (
   input  logic [SAMPLE_W-1:0] a_re,
   input  logic [SAMPLE_W-1:0] a_im,
   input  logic [SAMPLE_W-1:0] b_re,
   input  logic [SAMPLE_W-1:0] b_im,
   output logic [SAMPLE_W-1:0] y_re,
   output logic [SAMPLE_W-1:0] y_im
);

   generate
      if (SAMPLE_W < 2) begin : g_bad_width
         $error("gw_blend: SAMPLE_W must be at least 2");
      end
   endgenerate

   logic [SAMPLE_W-1:0] lane_a [GW_LANES];
   logic [SAMPLE_W-1:0] lane_b [GW_LANES];
   logic [SAMPLE_W-1:0] lane_y [GW_LANES];

   assign lane_a[0] = a_re;
   assign lane_a[1] = a_im;
   assign lane_b[0] = b_re;
   assign lane_b[1] = b_im;

   // Sign-extended sum with one guard bit, then drop the LSB: floor halving
   for (genvar l = 0; l < GW_LANES; l++) begin : g_lane
      logic [SAMPLE_W:0] sum;
      always_comb begin
         sum       = {lane_a[l][SAMPLE_W-1], lane_a[l]} + {lane_b[l][SAMPLE_W-1], lane_b[l]};
         lane_y[l] = sum[SAMPLE_W:1];
      end
   end

   assign y_re = lane_y[0];
   assign y_im = lane_y[1];

endmodule

// File: rtl/gw_seq.sv
`timescale 1ns/1ps
module gw_seq import gw_pkg::*; #(
   parameter int SYM_LEN   = 64,
   parameter int GUARD_LEN = 16,
   localparam int TOTAL    = SYM_LEN + GUARD_LEN,
   localparam int CW       = $clog2(TOTAL)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_sos,
   input  logic          in_last,
   input  logic          out_ready,
   output logic [CW-1:0] cnt,
   output gw_phase_e     phase,
   output logic          in_ready,
   output logic          out_valid,
   output logic          fire,
   output logic          err_align
);

   generate
      if (GUARD_LEN < 1 || GUARD_LEN >= SYM_LEN) begin : g_bad_guard
         $error("gw_seq: GUARD_LEN must lie in 1..SYM_LEN-1");
      end
   endgenerate

   logic tail_q;
   logic last_q;
   logic at_end;
   logic at_head;
   logic pass_fire;

   assign phase     = tail_q ? PH_TAIL :
                      (cnt < CW'(SYM_LEN)) ? PH_PASS : PH_REPLAY;
   assign in_ready  = (phase == PH_PASS) && out_ready;
   assign out_valid = (phase == PH_PASS) ? in_valid : 1'b1;
   assign fire      = out_valid && out_ready;
   assign at_end    = (cnt == CW'(TOTAL - 1));
   assign at_head   = (cnt == '0);
   assign pass_fire = fire && (phase == PH_PASS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         tail_q    <= 1'b0;
         last_q    <= 1'b0;
         err_align <= 1'b0;
      end else if (fire) begin
         if (phase == PH_TAIL) begin
            tail_q <= 1'b0;
         end else begin
            if (at_end) begin
               cnt    <= '0;
               tail_q <= last_q;
            end else begin
               cnt <= cnt + 1'b1;
            end
            if (pass_fire && at_head) last_q <= in_last;
            if (pass_fire && (in_sos != at_head)) err_align <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/ofdm_guard_window.sv
`timescale 1ns/1ps
module ofdm_guard_window import gw_pkg::*; #(
   parameter int SAMPLE_W  = 16,
   parameter int SYM_LEN   = 64,
   parameter int GUARD_LEN = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] in_re,
   input  logic [SAMPLE_W-1:0] in_im,
   input  logic                in_valid,
   input  logic                in_sos,
   input  logic                in_last,
   output logic                in_ready,
   output logic [SAMPLE_W-1:0] out_re,
   output logic [SAMPLE_W-1:0] out_im,
   output logic                out_valid,
   input  logic                out_ready,
   output logic                err_align
);

   localparam int TOTAL = SYM_LEN + GUARD_LEN;
   localparam int CW    = $clog2(TOTAL);
   localparam int AW    = (GUARD_LEN > 1) ? $clog2(GUARD_LEN) : 1;
   localparam int PW    = 2 * SAMPLE_W;

   generate
      if (SAMPLE_W < 2) begin : g_bad_sample
         $error("ofdm_guard_window: SAMPLE_W must be at least 2");
      end
      if (GUARD_LEN < 1 || GUARD_LEN >= SYM_LEN) begin : g_bad_len
         $error("ofdm_guard_window: GUARD_LEN must lie in 1..SYM_LEN-1");
      end
   endgenerate

   logic [CW-1:0] cnt;
   gw_phase_e     phase;
   logic          fire;

   gw_seq #(.SYM_LEN(SYM_LEN), .GUARD_LEN(GUARD_LEN)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sos    (in_sos),
      .in_last   (in_last),
      .out_ready (out_ready),
      .cnt       (cnt),
      .phase     (phase),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .fire      (fire),
      .err_align (err_align)
   );

   // Head store: indices 0..GUARD_LEN-1 of the current symbol
   logic          pass_fire;
   logic          buf_we;
   logic [CW-1:0] rel_cnt;
   logic [AW-1:0] buf_raddr;
   logic [PW-1:0] buf_rdata;

   assign pass_fire = fire && (phase == PH_PASS);
   assign buf_we    = pass_fire && (cnt < CW'(GUARD_LEN));
   assign rel_cnt   = cnt - CW'(SYM_LEN);
   assign buf_raddr = rel_cnt[AW-1:0];

   gw_hold_buf #(.DEPTH(GUARD_LEN), .DATA_W(PW)) i_buf (
      .clk     (clk),
      .wr_en   (buf_we),
      .wr_addr (cnt[AW-1:0]),
      .wr_data ({in_re, in_im}),
      .rd_addr (buf_raddr),
      .rd_data (buf_rdata)
   );

   // Edge term: index GUARD_LEN sample of the latest symbol, zero at frame start
   logic [SAMPLE_W-1:0] edge_re;
   logic [SAMPLE_W-1:0] edge_im;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         edge_re <= '0;
         edge_im <= '0;
      end else if (fire && (phase == PH_TAIL)) begin
         edge_re <= '0;
         edge_im <= '0;
      end else if (pass_fire && (cnt == CW'(GUARD_LEN))) begin
         edge_re <= in_re;
         edge_im <= in_im;
      end
   end

   logic [SAMPLE_W-1:0] mix_a_re;
   logic [SAMPLE_W-1:0] mix_a_im;
   logic [SAMPLE_W-1:0] mix_re;
   logic [SAMPLE_W-1:0] mix_im;

   assign mix_a_re = (phase == PH_TAIL) ? '0 : in_re;
   assign mix_a_im = (phase == PH_TAIL) ? '0 : in_im;

   gw_blend #(.SAMPLE_W(SAMPLE_W)) i_blend (
      .a_re (mix_a_re),
      .a_im (mix_a_im),
      .b_re (edge_re),
      .b_im (edge_im),
      .y_re (mix_re),
      .y_im (mix_im)
   );

   always_comb begin
      unique case (phase)
         PH_PASS: begin
            if (cnt == '0) begin
               out_re = mix_re;
               out_im = mix_im;
            end else begin
               out_re = in_re;
               out_im = in_im;
            end
         end
         PH_REPLAY: begin
            out_re = buf_rdata[PW-1:SAMPLE_W];
            out_im = buf_rdata[SAMPLE_W-1:0];
         end
         default: begin
            out_re = mix_re;
            out_im = mix_im;
         end
      endcase
   end

endmodule

// File: rtl/gw_checker.sv
`timescale 1ns/1ps
module gw_checker import gw_pkg::*; #(
   parameter int SAMPLE_W  = 16,
   parameter int SYM_LEN   = 64,
   parameter int GUARD_LEN = 16,
   localparam int CW       = $clog2(SYM_LEN + GUARD_LEN)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_ready,
   input logic                out_valid,
   input logic                out_ready,
   input logic [SAMPLE_W-1:0] out_re,
   input logic [SAMPLE_W-1:0] out_im,
   input logic                err_align,
   input logic [CW-1:0]       cnt,
   input gw_phase_e           phase
);

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(SYM_LEN + GUARD_LEN)); // R1

   AST_SRC_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_PASS) |-> !in_ready); // R2

   AST_TAIL_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_TAIL) |-> out_valid); // R4

   AST_TAIL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_TAIL && out_ready) |=> (phase != PH_TAIL)); // R4

   AST_IN_MEANS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> (out_valid && out_ready)); // R6

   AST_REPLAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_REPLAY && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im))); // R7

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_align |=> err_align); // R8

endmodule

bind ofdm_guard_window gw_checker #(
   .SAMPLE_W (SAMPLE_W),
   .SYM_LEN  (SYM_LEN),
   .GUARD_LEN(GUARD_LEN)
) i_gw_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_re    (out_re),
   .out_im    (out_im),
   .err_align (err_align),
   .cnt       (cnt),
   .phase     (phase)
);

// File: tb/test_ofdm_guard_window.sv
`timescale 1ns/100ps
module test_ofdm_guard_window;

   localparam int W   = 16;
   localparam int SYM = 64;
   localparam int GRD = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] in_re = '0, in_im = '0;
   logic         in_valid = 1'b0, in_sos = 1'b0, in_last = 1'b0;
   logic         in_ready;
   logic [W-1:0] out_re, out_im;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic         err_align;

   always #2 clk = ~clk;   // 250 MHz

   ofdm_guard_window #(.SAMPLE_W(W), .SYM_LEN(SYM), .GUARD_LEN(GRD)) i_ofdm_guard_window (
      .clk, .rst_n, .in_re, .in_im, .in_valid, .in_sos, .in_last, .in_ready,
      .out_re, .out_im, .out_valid, .out_ready, .err_align
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   bit stress = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   int    exp_re_q [$];
   int    exp_im_q [$];
   string exp_tag_q[$];
   int    edge_re = 0, edge_im = 0;   // model of the previous index-16 sample

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int sx(input logic [W-1:0] v);
      return int'($signed(v));
   endfunction

   function automatic int gen(input int sym, input int k, input int lane);
      int h;
      h = (sym * 977 + k * 131 + lane * 7919 + 17) * 40503;
      return int'($signed(h[W-1:0]));
   endfunction

   function automatic int half_floor(input int s);
      return s >>> 1;
   endfunction

   task automatic push_exp(input int re, input int im, input string tag);
      exp_re_q.push_back(re);
      exp_im_q.push_back(im);
      exp_tag_q.push_back(tag);
   endtask

   // Called at posedge + 0.5; returns at a later posedge + 0.5 after acceptance
   task automatic push_beat(input int re, input int im, input bit sos, input bit last);
      in_re = W'(re); in_im = W'(im); in_sos = sos; in_last = last; in_valid = 1'b1;
      forever begin
         #0.5;
         if (in_ready) begin
            @(posedge clk); #0.5;
            break;
         end
         @(posedge clk); #0.5;
      end
      in_valid = 1'b0;
   endtask

   // fixed: 0 = hashed content, else all samples re=fv, im=~fv
   task automatic send_symbol(input int sym, input bit fixed, input int fv,
                              input bit last, input int bad_sos_k);
      int xr [SYM];
      int xi [SYM];
      for (int k = 0; k < SYM; k++) begin
         xr[k] = fixed ? fv : gen(sym, k, 0);
         xi[k] = fixed ? (-1 - fv) : gen(sym, k, 1);
      end
      for (int k = 0; k < SYM; k++) begin
         if (k == 0) push_exp(half_floor(xr[0] + edge_re), half_floor(xi[0] + edge_im), "R3/R5/R9 blended head");
         else        push_exp(xr[k], xi[k], "R1/R6 pass-through");
         if (k == SYM - 1) begin
            for (int j = 0; j < GRD; j++) push_exp(xr[j], xi[j], "R1/R7 replay");
            if (last) push_exp(half_floor(xr[GRD]), half_floor(xi[GRD]), "R4/R9 tail");
         end
         while (stress && lfsr[3]) begin @(posedge clk); #0.5; end
         push_beat(xr[k], xi[k], (k == 0) || (k == bad_sos_k), (k == 0) && last);
      end
      edge_re = last ? 0 : xr[GRD];
      edge_im = last ? 0 : xi[GRD];
   endtask

   // Downstream ready and the stress LFSR change just after each rising edge
   initial begin
      forever begin
         @(posedge clk); #0.5;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         out_ready = stress ? (lfsr[0] | lfsr[5]) : 1'b1;
      end
   end

   // Monitor / scoreboard, sampled at the falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (in_valid && in_ready)
            check(out_valid && out_ready, "R6 input accepted without same-cycle output", int'(out_valid), 1);
         if (out_valid && out_ready) begin
            if (exp_re_q.size() == 0) begin
               check(1'b0, "R7 unexpected extra output", sx(out_re), 0);
            end else begin
               int er, ei;
               string tg;
               er = exp_re_q.pop_front();
               ei = exp_im_q.pop_front();
               tg = exp_tag_q.pop_front();
               check(sx(out_re) == er, {tg, " re"}, sx(out_re), er);
               check(sx(out_im) == ei, {tg, " im"}, sx(out_im), ei);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", exp_re_q.size(), 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #0.5 rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1 idle after reset out_valid", int'(out_valid), 0);
      check(err_align == 1'b0, "R8 err_align after reset", int'(err_align), 0);
      check(in_ready == 1'b1, "R2 in_ready idle with downstream ready", int'(in_ready), 1);
      @(posedge clk); #0.5;

      // Frame A: three hashed symbols, no stalls
      send_symbol(1, 1'b0, 0, 1'b0, -1);
      send_symbol(2, 1'b0, 0, 1'b0, -1);
      send_symbol(3, 1'b0, 0, 1'b1, -1);

      // Frame B: stalls on both sides, including inside replay and tail
      stress = 1'b1;
      send_symbol(4, 1'b0, 0, 1'b0, -1);
      send_symbol(5, 1'b0, 0, 1'b0, -1);
      send_symbol(6, 1'b0, 0, 1'b1, -1);
      stress = 1'b0;

      // Frame C: full-scale corners, blend of -32768 with 32767 gives -1
      send_symbol(7, 1'b1, -32768, 1'b0, -1);
      send_symbol(8, 1'b1, 32767, 1'b1, -1);
      // Frame D: odd negative head and tail round toward minus infinity
      send_symbol(9, 1'b1, -32767, 1'b1, -1);

      repeat (30) @(posedge clk);
      @(negedge clk);
      check(err_align == 1'b0, "R8 err_align stays low on aligned traffic", int'(err_align), 0);
      @(posedge clk); #0.5;

      // Frame E: stray start mark at index 5; positions must not move
      send_symbol(10, 1'b0, 0, 1'b1, 5);
      repeat (30) @(posedge clk);
      @(negedge clk);
      check(err_align == 1'b1, "R8 err_align set by misplaced start", int'(err_align), 1);
      check(exp_re_q.size() == 0, "R7 every expected sample delivered", exp_re_q.size(), 0);
      check(out_valid == 1'b0, "R2 idle after final tail", int'(out_valid), 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule